// File: doc/BRIEF.md
# SPI Serial Memory Slave with Region Write Lock

This block is the slave side of a small serial memory reached over SPI (mode 0: data in is sampled on the rising serial clock and data out changes on the falling one). It runs from a system clock and sees chip select, serial clock and serial data in as synchronous inputs. It detects their edges, assembles command bytes MSB first and serves reads, writes and status reads on a 512-byte array. Writes require an armed write-enable latch. A 3-bit lock code in the status register selects one fixed address region whose bytes cannot be written.

A write or lock update is held pending while the transfer is in progress. It takes effect only when chip select is released exactly on a byte boundary. A modelled busy period follows each commit. During that period only the status command is served, and at its end the write-enable latch drops.

The controller states are: `ST_IDLE` (standby), `ST_OPCODE` (collect command), `ST_ADDR` (collect low address), `ST_WDATA` (collect write byte), `ST_RDATA` (stream array), `ST_STATUS` (stream status), `ST_LOCKB` (collect lock byte) and `ST_SKIP` (discard the rest of an ignored command). The transitions are: chip select high goes to `ST_IDLE` from any state; a chip-select fall goes from `ST_IDLE` to `ST_OPCODE`; the first complete byte in `ST_OPCODE` goes to `ST_STATUS`, `ST_ADDR`, `ST_LOCKB` or `ST_SKIP` according to the decode; the address byte in `ST_ADDR` goes to `ST_WDATA` or `ST_RDATA`. The states `ST_WDATA`, `ST_LOCKB`, `ST_RDATA`, `ST_STATUS` and `ST_SKIP` hold until chip select rises.

Top module: `spi_lock_mem`

## Requirements
- R1: After reset the write-enable latch, the lock code and the write-in-progress flag are all zero, so a status read returns 0x00, and `sdo_oe` is low.
- R2: The block accepts an instruction only after it has seen a falling edge of `cs_n`. Bytes clocked while `cs_n` was already low at reset release are ignored, and `sdo_oe` is low whenever `cs_n` is high.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Nothing else sets the latch.
- R4: A write command or a lock-write command sent while the write-enable latch is clear changes nothing.
- R5: Write opcodes are 0x02 and 0x0A, with opcode bit 3 carrying address bit 8 and the next byte carrying address bits 7:0. Each later complete byte replaces the pending one, and the last complete byte is stored when `cs_n` rises.
- R6: If `cs_n` rises while the bit count within a byte is not zero, the pending write or lock update is discarded and the write-enable latch stays set.
- R7: Read opcodes are 0x03 and 0x0B, with address bits placed as in R5. Bytes stream out MSB first, the address increments after each byte and wraps from 0x1FF to 0x000.
- R8: Opcode 0x01 is followed by a lock byte. Bits 2:0 of that byte become the lock code, the last complete byte is the one committed, and a byte with any of bits 7:3 set is refused.
- R9: Lock code 0 protects nothing. Codes 1 to 4 protect 0x000–0x07F, 0x080–0x0FF, 0x100–0x17F and 0x180–0x1FF. Code 5 protects 0x000–0x0FF, code 6 protects 0x000–0x00F and code 7 protects 0x1F0–0x1FF. A write byte aimed at a protected address is dropped silently.
- R10: A committed write or lock update sets write-in-progress for `BUSY_CYCLES` clocks. When write-in-progress clears, the write-enable latch clears too.
- R11: While write-in-progress is set, every command except the status read (0x05) is ignored, and `sdo_oe` stays low.
- R12: The status byte has write-in-progress at bit 0, the write-enable latch at bit 1 and the lock code at bits 4:2. All other bits read zero. The status byte repeats for as long as clocks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, zero when not enabled |
| sdo_oe | output | 1 | Tristate enable for `sdo` |

## Verification
Writes are tried with every lock code against addresses placed on both sides of each region edge (0x00F/0x010, 0x07F/0x080, 0x0FF/0x100, 0x17F/0x180, 0x1EF/0x1F0). This distinguishes an off-by-one range from a correct one and a wrong code-to-region mapping from the right one. Multi-byte writes and lock writes show whether the last or the first byte is kept. A chip-select release three bits into a byte separates an abort from a commit. A burst read from 0x1FF shows whether the address wraps. A read issued during the busy period, and a preload of bytes while `cs_n` is low at reset release, show whether ignored commands ever drive the data pin or touch the latch.

// File: rtl/spi_lock_pkg.sv
package spi_lock_pkg;

    localparam int ADDR_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_LOCK = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_RD   = 8'h03;
    localparam logic [7:0] OP_WR   = 8'h02;
    localparam logic [7:0] OP_A8   = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_WDATA,
        ST_RDATA, ST_STATUS, ST_LOCKB, ST_SKIP
    } st_t;

    // Region guarded by each lock code.
    function automatic logic in_lock(input logic [2:0] code,
                                     input logic [ADDR_W-1:0] a);
        logic hit;
        case (code)
            3'd1:    hit = (a[8:7] == 2'd0);
            3'd2:    hit = (a[8:7] == 2'd1);
            3'd3:    hit = (a[8:7] == 2'd2);
            3'd4:    hit = (a[8:7] == 2'd3);
            3'd5:    hit = (a[8] == 1'b0);
            3'd6:    hit = (a[8:4] == 5'h00);
            3'd7:    hit = (a[8:4] == 5'h1F);
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spi_lock_rx.sv
module spi_lock_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       sck_fall,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       on_boundary
);
    logic       sck_q;
    logic       cs_q;
    logic [6:0] sr;
    logic [2:0] cnt;
    logic       sck_rise;

    // cs_q resets low so a select already held low at release is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b0;
            sr    <= '0;
            cnt   <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                cnt <= '0;
            end else if (sck_rise) begin
                sr  <= {sr[5:0], sdi};
                cnt <= cnt + 3'd1;
            end
        end
    end

    always_comb begin
        cs_fall     = cs_q & ~cs_n;
        cs_rise     = ~cs_q & cs_n;
        sck_rise    = ~cs_n & sck & ~sck_q;
        sck_fall    = ~cs_n & ~sck & sck_q;
        byte_done   = sck_rise && (cnt == 3'd7);
        byte_val    = {sr, sdi};
        on_boundary = (cnt == 3'd0);
    end

endmodule

// File: rtl/spi_lock_busy.sv
module spi_lock_busy #(
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        busy = (cnt != '0);
        done = (cnt == CW'(1));
    end

    // R10: a new commit never restarts a running busy period
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/spi_lock_store.sv
module spi_lock_store #(
    parameter int DEPTH = 512,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spi_lock_mem.sv
module spi_lock_mem
    import spi_lock_pkg::*;
#(
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic              cs_fall, cs_rise, sck_fall, byte_done, on_boundary;
    logic [7:0]        byte_val;
    logic              busy, busy_done, busy_start;
    logic              mem_we;
    logic [7:0]        rdata;

    st_t               state, op_state;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        pend;
    logic              got;
    logic              is_wr;
    logic              wel;
    logic [2:0]        lock_code;
    logic [7:0]        out_sr;
    logic              out_vld;
    logic [7:0]        status;
    logic              op_read, op_write, commit_ok, wr_commit, lock_commit;

    spi_lock_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_fall(sck_fall),
        .byte_done(byte_done), .byte_val(byte_val), .on_boundary(on_boundary)
    );

    spi_lock_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start),
        .busy(busy), .done(busy_done)
    );

    spi_lock_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk(clk), .we(mem_we), .waddr(addr), .wdata(pend),
        .raddr(addr), .rdata(rdata)
    );

    // Opcode decode and commit conditions
    always_comb begin
        op_read  = ((byte_val & ~OP_A8) == OP_RD);
        op_write = ((byte_val & ~OP_A8) == OP_WR);
        if (byte_val == OP_RDSR)                op_state = ST_STATUS;
        else if (busy)                          op_state = ST_SKIP;
        else if (op_read)                       op_state = ST_ADDR;
        else if (op_write && wel)               op_state = ST_ADDR;
        else if (byte_val == OP_LOCK && wel)    op_state = ST_LOCKB;
        else                                    op_state = ST_SKIP;
        commit_ok   = cs_rise && on_boundary && got && !busy;
        wr_commit   = commit_ok && (state == ST_WDATA);
        lock_commit = commit_ok && (state == ST_LOCKB) && (pend[7:3] == 5'd0);
        mem_we      = wr_commit && !in_lock(lock_code, addr);
        busy_start  = wr_commit || lock_commit;
        status      = {3'b000, lock_code, wel, busy};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (cs_n) begin
            state <= ST_IDLE;
        end else if (cs_fall) begin
            state <= ST_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                ST_OPCODE: state <= op_state;
                ST_ADDR:   state <= is_wr ? ST_WDATA : ST_RDATA;
                default:   state <= state;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            lock_code <= 3'd0;
            addr      <= '0;
            pend      <= '0;
            got       <= 1'b0;
            is_wr     <= 1'b0;
            out_sr    <= '0;
            out_vld   <= 1'b0;
        end else begin
            if (busy_done) wel <= 1'b0;
            if (cs_fall) got <= 1'b0;
            if (state == ST_OPCODE && byte_done && !busy) begin
                if (byte_val == OP_WREN) wel <= 1'b1;
                if (byte_val == OP_WRDI) wel <= 1'b0;
                is_wr   <= op_write;
                addr[8] <= byte_val[3];
            end
            if (state == ST_ADDR && byte_done) addr[7:0] <= byte_val;
            if ((state == ST_WDATA || state == ST_LOCKB) && byte_done) begin
                pend <= byte_val;
                got  <= 1'b1;
            end
            if (lock_commit) lock_code <= pend[2:0];
            if (sck_fall && (state == ST_RDATA || state == ST_STATUS)) begin
                if (on_boundary) begin
                    out_sr  <= (state == ST_RDATA) ? rdata : status;
                    out_vld <= 1'b1;
                    if (state == ST_RDATA) addr <= addr + 9'd1;
                end else begin
                    out_sr <= {out_sr[6:0], 1'b0};
                end
            end
            if (cs_n) out_vld <= 1'b0;
        end
    end

    // Serial output
    always_comb begin
        sdo_oe = out_vld && !cs_n && (state == ST_RDATA || state == ST_STATUS);
        sdo    = sdo_oe ? out_sr[7] : 1'b0;
    end

    // R2: data pin released whenever the chip is deselected
    p_oe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo_oe);

    // R3: the latch only rises after a decoded set-enable opcode
    p_wel_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(state == ST_OPCODE && byte_done && byte_val == OP_WREN));

    // R8: lock code changes only right after chip select released
    p_lock_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_code) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R11: no array store while a busy period runs
    p_store_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy);

    // R10: latch is down once the busy period has ended
    p_wel_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

endmodule

// File: tb/sim_spi_lock_mem.sv
module sim_spi_lock_mem;
    localparam int BUSY = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;

    int   checks = 0;
    int   errors = 0;
    bit   quiet = 1'b0;
    logic [7:0] ref_mem [512];
    int   ref_lock = 0;
    logic [7:0] dmy, got_b, s;
    int   addrs [12] = '{12'h000, 12'h00F, 12'h010, 12'h07F, 12'h080, 12'h0FF,
                         12'h100, 12'h17F, 12'h180, 12'h1EF, 12'h1F0, 12'h1FF};

    always #4 clk = ~clk;

    spi_lock_mem #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock model of the data pin enable (R2 deselected, R11 ignored read)
    always @(negedge clk) begin
        if (rst_n && (cs_n || quiet)) begin
            checks++;
            if (sdo_oe !== 1'b0) begin
                errors++;
                $display("FAIL %s sdo_oe actual %b expected 0", quiet ? "R11" : "R2", sdo_oe);
            end
        end
    end

    function automatic bit ref_prot(input int code, input int a);
        int lo, hi;
        lo = 1; hi = 0;
        case (code)
            1: begin lo = 0;   hi = 127; end
            2: begin lo = 128; hi = 255; end
            3: begin lo = 256; hi = 383; end
            4: begin lo = 384; hi = 511; end
            5: begin lo = 0;   hi = 255; end
            6: begin lo = 0;   hi = 15;  end
            7: begin lo = 496; hi = 511; end
            default: ;
        endcase
        return (a >= lo) && (a <= hi);
    endfunction

    task automatic cs_lo;
        @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi;
        @(negedge clk); cs_n = 1'b1; repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sdi = tx[i];
            repeat (2) @(negedge clk); rx[i] = sdo; sck = 1'b1;
            repeat (2) @(negedge clk); sck = 1'b0;
        end
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sdi = 1'b1;
            repeat (2) @(negedge clk); sck = 1'b1;
            repeat (2) @(negedge clk); sck = 1'b0;
        end
    endtask

    task automatic rd_status(output logic [7:0] st);
        logic [7:0] d;
        cs_lo; xfer(8'h05, d); xfer(8'h00, st); cs_hi;
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        cs_lo; xfer(op, d); cs_hi;
    endtask

    task automatic wait_idle;
        repeat (BUSY + 4) @(negedge clk);
    endtask

    task automatic mem_write(input int a, input logic [7:0] d);
        logic [7:0] x;
        op1(8'h06);
        cs_lo; xfer({4'b0, a[8], 3'b010}, x); xfer(a[7:0], x); xfer(d, x); cs_hi;
        if (!ref_prot(ref_lock, a)) ref_mem[a] = d;
        wait_idle;
    endtask

    task automatic mem_read(input int a, output logic [7:0] d);
        logic [7:0] x;
        cs_lo; xfer({4'b0, a[8], 3'b011}, x); xfer(a[7:0], x); xfer(8'h00, d); cs_hi;
    endtask

    task automatic set_lock(input int code);
        logic [7:0] x;
        op1(8'h06);
        cs_lo; xfer(8'h01, x); xfer(code[7:0], x); cs_hi;
        ref_lock = code;
        wait_idle;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected finish");
        report;
        $finish;
    end

    initial begin
        // R2: chip select already low across reset release
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sdo_oe after reset", {31'd0, sdo_oe}, 32'd0);
        xfer(8'h06, dmy);
        cs_hi;
        rd_status(s);
        chk("R2 no instruction without cs fall", {24'd0, s}, 32'h00);
        chk("R1 status after reset", {24'd0, s}, 32'h00);

        // R3: set / clear latch
        op1(8'h06); rd_status(s);
        chk("R3 WREN sets latch", {24'd0, s}, 32'h02);
        op1(8'h04); rd_status(s);
        chk("R3 WRDI clears latch", {24'd0, s}, 32'h00);

        // Preload addresses with lock 0
        foreach (addrs[i]) mem_write(addrs[i], 8'h10 + 8'(i));
        mem_write(12'h020, 8'h44);

        // R4: write without latch
        begin
            logic [7:0] x;
            cs_lo; xfer(8'h02, x); xfer(8'h20, x); xfer(8'hAA, x); cs_hi;
        end
        repeat (4) @(negedge clk);
        mem_read(12'h020, got_b);
        chk("R4 write ignored without latch", {24'd0, got_b}, 32'h44);
        begin
            logic [7:0] x;
            cs_lo; xfer(8'h01, x); xfer(8'h05, x); cs_hi;
        end
        rd_status(s);
        chk("R4 lock-write ignored without latch", {24'd0, s}, 32'h00);

        // R6: abort off byte boundary
        op1(8'h06);
        begin
            logic [7:0] x;
            cs_lo; xfer(8'h02, x); xfer(8'h20, x); xfer(8'h77, x); bits(3); cs_hi;
        end
        rd_status(s);
        chk("R6 abort keeps latch, no busy", {24'd0, s}, 32'h02);
        mem_read(12'h020, got_b);
        chk("R6 aborted byte not stored", {24'd0, got_b}, 32'h44);
        op1(8'h04);

        // R5 / R10 / R11: two data bytes to 0x1FF, last one kept
        op1(8'h06);
        begin
            logic [7:0] x;
            cs_lo; xfer(8'h0A, x); xfer(8'hFF, x); xfer(8'h11, x); xfer(8'h22, x); cs_hi;
        end
        ref_mem[511] = 8'h22;
        quiet = 1'b1;
        mem_read(12'h020, got_b);
        quiet = 1'b0;
        chk("R11 read during busy gives no data", {24'd0, got_b}, 32'h00);
        rd_status(s);
        chk("R10 write-in-progress set after commit", {31'd0, s[0]}, 32'd1);
        chk("R12 latch bit during busy", {31'd0, s[1]}, 32'd1);
        wait_idle;
        rd_status(s);
        chk("R10 busy over, latch cleared", {24'd0, s}, 32'h00);

        // R7: burst read wraps 0x1FF -> 0x000
        mem_write(12'h000, 8'h33);
        begin
            logic [7:0] b0, b1, x;
            cs_lo; xfer(8'h0B, x); xfer(8'hFF, x); xfer(8'h00, b0); xfer(8'h00, b1); cs_hi;
            chk("R5 last byte stored at 0x1FF", {24'd0, b0}, 32'h22);
            chk("R7 wrap to 0x000", {24'd0, b1}, 32'h33);
        end

        // R8: last lock byte committed; upper bits refuse
        op1(8'h06);
        begin
            logic [7:0] x;
            cs_lo; xfer(8'h01, x); xfer(8'h07, x); xfer(8'h03, x); cs_hi;
        end
        ref_lock = 3;
        wait_idle;
        rd_status(s);
        chk("R8 last lock byte committed", {24'd0, s}, 32'h0C);
        op1(8'h06);
        begin
            logic [7:0] x;
            cs_lo; xfer(8'h01, x); xfer(8'h09, x); cs_hi;
        end
        rd_status(s);
        chk("R8 lock byte with upper bits refused", {24'd0, s}, 32'h0E);
        op1(8'h04);

        // R9: every lock code against region edges
        for (int code = 0; code < 8; code++) begin
            set_lock(code);
            rd_status(s);
            chk("R12 lock field in status", {24'd0, s}, 32'(code << 2));
            foreach (addrs[i]) mem_write(addrs[i], 8'(code * 16 + i) ^ 8'hA5);
            foreach (addrs[i]) begin
                mem_read(addrs[i], got_b);
                chk($sformatf("R9 code %0d addr %h", code, addrs[i]),
                    {24'd0, got_b}, {24'd0, ref_mem[addrs[i]]});
            end
        end

        report;
        $finish;
    end

endmodule